// File: doc/BRIEF.md
# Integer-versus-Extended-Float Comparator

This block decides how an 80-bit extended-precision floating-point operand relates to a signed integer. The float operand has a sign bit, a 15-bit biased exponent and a 64-bit significand whose top bit is an explicit integer bit. The integer is 32 bits wide, or 16 bits wide when the narrow select is set. The integer is first turned exactly into the same extended form (sign, exponent, normalized significand). The two values are then compared, and the block returns a three-bit condition code together with invalid, stack-fault and denormal flags.

The comparison is unordered. A NaN or any encoding the format does not support gives its own all-ones code instead of an ordering, and the two signs of zero count as the same value. The caller also reports whether the top-of-stack register is empty. The caller can ask for the stack to be popped after the comparison, and the block passes that request on in the cycle the result is ready. Result and flags are registered. They keep their values until the next request.

Top module: `intFloatCmp`

## Requirements
- R1: One cycle after a request, ccOut = {C3,C2,C0} is 3'b000 when the float is greater than the integer, 3'b001 when it is less, and 3'b100 when the two are equal.
- R2: With intNarrow=1 only intIn[15:0] is used, as a signed 16-bit value, and intIn[31:16] has no effect. With intNarrow=0 all 32 bits are used as a signed value.
- R3: The integer is converted with no rounding, so the 32-bit extremes -2147483648 and 2147483647 compare equal to their exact float values, and they compare less than a float one unit of the integer above them.
- R4: A float zero of either sign compares equal to integer zero.
- R5: A NaN (exponent all ones, integer bit 1, fraction non-zero) gives ccOut=3'b111 and invalidOut=1.
- R6: Unsupported encodings give ccOut=3'b111 and invalidOut=1. These are a pseudo-infinity or pseudo-NaN (exponent all ones, integer bit 0) and an unnormal (exponent neither zero nor all ones, integer bit 0).
- R7: A float infinity (exponent all ones, significand 0x8000000000000000) is greater than every integer when positive and less than every integer when negative.
- R8: A float with exponent 0 and a non-zero significand sets denormOut=1, and it is still ordered by its true value.
- R9: When stEmpty=1 at the request, stackFault=1, invalidOut=1, denormOut=0 and ccOut=3'b111, whatever the operands are.
- R10: popOut is high for exactly the one cycle in which doneOut is high, and only when popReq was 1 with the request.
- R11: doneOut is high in the cycle after each cycle with inValid=1 and low otherwise. ccOut and the flags change only after a request.
- R12: After reset, ccOut=3'b000 and invalidOut, stackFault, denormOut, popOut and doneOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; operands are sampled in this cycle |
| fpIn | input | 80 | Extended float: [79] sign, [78:64] exponent, [63:0] significand |
| intIn | input | 32 | Signed integer operand |
| intNarrow | input | 1 | 1 selects the signed 16-bit integer intIn[15:0] |
| popReq | input | 1 | Request a stack pop after the comparison |
| stEmpty | input | 1 | Top-of-stack register is empty |
| ccOut | output | 3 | {C3,C2,C0} condition code |
| invalidOut | output | 1 | Invalid operand or stack fault |
| stackFault | output | 1 | Comparison against an empty register |
| denormOut | output | 1 | Float operand was denormal |
| popOut | output | 1 | Pop request to the stack controller |
| doneOut | output | 1 | Result valid strobe |

## Verification
The stimulus table pairs floats with integers of the same sign and of opposite signs, with equal and unequal magnitudes, and with magnitudes that differ only in the lowest integer unit. This separates a sign-only decision from a real magnitude compare, and it exposes a conversion that loses low bits. The same integer bits are applied with both width settings to show that the narrow path sign-extends and ignores the upper half. Zeros of both signs, infinities, NaNs, each unsupported class and true and pseudo denormals test the classifier against the ordering path. Directed runs cover an empty register, pop forwarding, back-to-back requests, and outputs holding while the inputs change.

// File: rtl/intFloatCmp_pkg.sv
package intFloatCmp_pkg;
  localparam int EXP_W    = 15;
  localparam int MAN_W    = 64;
  localparam int INT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int FP_W     = 1 + EXP_W + MAN_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int PAD_W    = MAN_W - INT_W;
  localparam int LZ_W     = $clog2(INT_W) + 1;
  localparam int KEY_W    = EXP_W + MAN_W;

  typedef enum logic [2:0] {
    CC_GT = 3'b000,
    CC_LT = 3'b001,
    CC_EQ = 3'b100,
    CC_UN = 3'b111
  } ccCode_t;

  typedef struct packed {
    logic capture;
  } ctlStrobe_t;

  function automatic logic [LZ_W-1:0] leadZeros(input logic [INT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic seen;
    n = '0;
    seen = 1'b0;
    for (int k = INT_W - 1; k >= 0; k--) begin
      if (!seen) begin
        if (v[k]) seen = 1'b1;
        else n = n + LZ_W'(1);
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/intFloatCmp_ctl.sv
module intFloatCmp_ctl
  import intFloatCmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       popReq,
  output ctlStrobe_t strobe,
  output logic       popOut,
  output logic       doneOut
);
  // The datapath captures in the request cycle; done and pop follow one edge later.
  always_comb strobe.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOut <= 1'b0;
      popOut  <= 1'b0;
    end else begin
      doneOut <= inValid;
      popOut  <= inValid & popReq;
    end
  end
endmodule

// File: rtl/intFloatCmp_dp.sv
module intFloatCmp_dp
  import intFloatCmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [FP_W-1:0]  fpIn,
  input  logic [INT_W-1:0] intIn,
  input  logic             intNarrow,
  input  logic             stEmpty,
  output logic [2:0]       ccOut,
  output logic             invalidOut,
  output logic             stackFault,
  output logic             denormOut
);
  // Float fields
  logic             fSign;
  logic [EXP_W-1:0] fExp;
  logic [MAN_W-1:0] fMan;
  assign fSign = fpIn[FP_W-1];
  assign fExp  = fpIn[FP_W-2 -: EXP_W];
  assign fMan  = fpIn[MAN_W-1:0];

  logic jBit, expMax, expZero, fracZero;
  assign jBit     = fMan[MAN_W-1];
  assign expMax   = &fExp;
  assign expZero  = (fExp == '0);
  assign fracZero = (fMan[MAN_W-2:0] == '0);

  // Classification: infinities order normally, every other all-ones
  // exponent and every unnormal is unordered.
  logic isInf, isBad, fZero, isDen;
  assign isInf = expMax & jBit & fracZero;
  assign isBad = (expMax & ~isInf) | (~expMax & ~expZero & ~jBit);
  assign fZero = expZero & (fMan == '0);
  assign isDen = expZero & ~fZero;

  // Exact integer to extended conversion
  logic [INT_W-1:0] intExt, iMag;
  logic             iNeg, iZero;
  logic [LZ_W-1:0]  lz;
  logic [EXP_W-1:0] iExp;
  logic [MAN_W-1:0] iMan;

  assign intExt = intNarrow ? {{(INT_W-NARROW_W){intIn[NARROW_W-1]}}, intIn[NARROW_W-1:0]}
                            : intIn;
  assign iNeg   = intExt[INT_W-1];
  assign iMag   = iNeg ? (~intExt + INT_W'(1)) : intExt;
  assign iZero  = (iMag == '0);
  assign lz     = leadZeros(iMag);
  assign iExp   = EXP_W'(BIAS + INT_W - 1 - int'(lz));
  assign iMan   = {iMag << lz, {PAD_W{1'b0}}};

  // Magnitude compare on {exponent, significand}
  logic [KEY_W-1:0] fKey, iKey;
  logic magGt, magEq;
  assign fKey  = {fExp, fMan};
  assign iKey  = {iExp, iMan};
  assign magGt = fKey > iKey;
  assign magEq = fKey == iKey;

  ccCode_t relNext;
  always_comb begin
    if (stEmpty || isBad)       relNext = CC_UN;
    else if (fZero && iZero)    relNext = CC_EQ;
    else if (fZero)             relNext = iNeg ? CC_GT : CC_LT;
    else if (iZero)             relNext = fSign ? CC_LT : CC_GT;
    else if (fSign != iNeg)     relNext = fSign ? CC_LT : CC_GT;
    else if (magEq)             relNext = CC_EQ;
    else if (magGt ^ fSign)     relNext = CC_GT;
    else                        relNext = CC_LT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccOut      <= CC_GT;
      invalidOut <= 1'b0;
      stackFault <= 1'b0;
      denormOut  <= 1'b0;
    end else if (strobe.capture) begin
      ccOut      <= relNext;
      invalidOut <= stEmpty | isBad;
      stackFault <= stEmpty;
      denormOut  <= ~stEmpty & isDen;
    end
  end
endmodule

// File: rtl/intFloatCmp.sv
module intFloatCmp
  import intFloatCmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [FP_W-1:0]  fpIn,
  input  logic [INT_W-1:0] intIn,
  input  logic             intNarrow,
  input  logic             popReq,
  input  logic             stEmpty,
  output logic [2:0]       ccOut,
  output logic             invalidOut,
  output logic             stackFault,
  output logic             denormOut,
  output logic             popOut,
  output logic             doneOut
);
  ctlStrobe_t strobe;

  intFloatCmp_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .popReq  (popReq),
    .strobe  (strobe),
    .popOut  (popOut),
    .doneOut (doneOut)
  );

  intFloatCmp_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fpIn       (fpIn),
    .intIn      (intIn),
    .intNarrow  (intNarrow),
    .stEmpty    (stEmpty),
    .ccOut      (ccOut),
    .invalidOut (invalidOut),
    .stackFault (stackFault),
    .denormOut  (denormOut)
  );
endmodule

// File: rtl/intFloatCmp_chk.sv
module intFloatCmp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       popReq,
  input logic       stEmpty,
  input logic [2:0] ccOut,
  input logic       invalidOut,
  input logic       stackFault,
  input logic       denormOut,
  input logic       popOut,
  input logic       doneOut
);
  a_r11_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> doneOut);
  a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !doneOut);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(ccOut) && $stable(invalidOut) && $stable(denormOut)));
  a_r10_pop_with_done: assert property (@(posedge clk) disable iff (!rstN)
    popOut |-> doneOut);
  a_r10_pop_forward: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && popReq) |=> popOut);
  a_r9_empty: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && stEmpty) |=> (stackFault && invalidOut && !denormOut && ccOut == 3'b111));
  a_r5_invalid_unordered: assert property (@(posedge clk) disable iff (!rstN)
    invalidOut |-> (ccOut == 3'b111));
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (ccOut == 3'b000 || ccOut == 3'b001 || ccOut == 3'b100 || ccOut == 3'b111));
  a_r8_denorm_ordered: assert property (@(posedge clk) disable iff (!rstN)
    denormOut |-> !invalidOut);
endmodule

bind intFloatCmp intFloatCmp_chk u_chk (.*);

// File: tb/intFloatCmp_tb.sv
module intFloatCmp_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [79:0] fpIn;
  logic [31:0] intIn;
  logic        intNarrow, popReq, stEmpty;
  logic [2:0]  ccOut;
  logic        invalidOut, stackFault, denormOut, popOut, doneOut;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  intFloatCmp u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fpIn(fpIn), .intIn(intIn),
    .intNarrow(intNarrow), .popReq(popReq), .stEmpty(stEmpty), .ccOut(ccOut),
    .invalidOut(invalidOut), .stackFault(stackFault), .denormOut(denormOut),
    .popOut(popOut), .doneOut(doneOut)
  );

  typedef struct packed {
    logic [79:0] fp;
    logic [31:0] iv;
    logic        nar;
    logic [2:0]  cc;
    logic        inv;
    logic        den;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{80'h3FFFC000000000000000, 32'h00000001, 1'b0, 3'b000, 1'b0, 1'b0, 4'd1},
    '{80'h3FFF8000000000000000, 32'h00000002, 1'b0, 3'b001, 1'b0, 1'b0, 4'd1},
    '{80'h4001A000000000000000, 32'h00000005, 1'b0, 3'b100, 1'b0, 1'b0, 4'd1},
    '{80'hBFFF8000000000000000, 32'h00000001, 1'b0, 3'b001, 1'b0, 1'b0, 4'd1},
    '{80'hBFFF8000000000000000, 32'hFFFFFFFF, 1'b0, 3'b100, 1'b0, 1'b0, 4'd1},
    '{80'hC0008000000000000000, 32'hFFFFFFFF, 1'b0, 3'b001, 1'b0, 1'b0, 4'd1},
    '{80'h401E8000000000000000, 32'h7FFFFFFF, 1'b0, 3'b000, 1'b0, 1'b0, 4'd3},
    '{80'h401DFFFFFFFE00000000, 32'h7FFFFFFF, 1'b0, 3'b100, 1'b0, 1'b0, 4'd3},
    '{80'hC01E8000000000000000, 32'h80000000, 1'b0, 3'b100, 1'b0, 1'b0, 4'd3},
    '{80'hC01DFFFFFFFE00000000, 32'h80000000, 1'b0, 3'b000, 1'b0, 1'b0, 4'd3},
    '{80'hC00E8000000000000000, 32'hABCD8000, 1'b1, 3'b100, 1'b0, 1'b0, 4'd2},
    '{80'hC00E8000000000000000, 32'hABCD8000, 1'b0, 3'b000, 1'b0, 1'b0, 4'd2},
    '{80'h400DFFFE000000000000, 32'h12347FFF, 1'b1, 3'b100, 1'b0, 1'b0, 4'd2},
    '{80'h80000000000000000000, 32'h00000000, 1'b0, 3'b100, 1'b0, 1'b0, 4'd4},
    '{80'h00000000000000000000, 32'h00000000, 1'b0, 3'b100, 1'b0, 1'b0, 4'd4},
    '{80'h00000000000000000000, 32'hFFFFFFFF, 1'b0, 3'b000, 1'b0, 1'b0, 4'd4},
    '{80'h80000000000000000000, 32'h00000001, 1'b0, 3'b001, 1'b0, 1'b0, 4'd4},
    '{80'h7FFF8000000000000000, 32'h7FFFFFFF, 1'b0, 3'b000, 1'b0, 1'b0, 4'd7},
    '{80'hFFFF8000000000000000, 32'h80000000, 1'b0, 3'b001, 1'b0, 1'b0, 4'd7},
    '{80'h7FFFC000000000000000, 32'h00000000, 1'b0, 3'b111, 1'b1, 1'b0, 4'd5},
    '{80'hFFFF8000000000000001, 32'h00000005, 1'b0, 3'b111, 1'b1, 1'b0, 4'd5},
    '{80'h7FFF0000000000000000, 32'h00000001, 1'b0, 3'b111, 1'b1, 1'b0, 4'd6},
    '{80'h3FFF4000000000000000, 32'h00000001, 1'b0, 3'b111, 1'b1, 1'b0, 4'd6},
    '{80'h7FFF4000000000000001, 32'h00000000, 1'b0, 3'b111, 1'b1, 1'b0, 4'd6},
    '{80'h00000000000000000001, 32'h00000000, 1'b0, 3'b000, 1'b0, 1'b1, 4'd8},
    '{80'h80000000000000000001, 32'h00000001, 1'b0, 3'b001, 1'b0, 1'b1, 4'd8},
    '{80'h00008000000000000000, 32'hFFFFFFFF, 1'b0, 3'b000, 1'b0, 1'b1, 4'd8}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge; sample at the next falling edge,
  // after the single capturing rising edge.
  task automatic request(input logic [79:0] f, input logic [31:0] i, input logic nar,
                         input logic pop, input logic emp);
    @(negedge clk);
    fpIn = f; intIn = i; intNarrow = nar; popReq = pop; stEmpty = emp; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; popReq = 1'b0; stEmpty = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; fpIn = '0; intIn = '0;
    intNarrow = 1'b0; popReq = 1'b0; stEmpty = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "ccOut", 80'(ccOut), 80'(3'b000));
    check("R12", "flags", 80'({invalidOut, stackFault, denormOut, popOut, doneOut}), 80'(0));
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      request(VEC[k].fp, VEC[k].iv, VEC[k].nar, 1'b0, 1'b0);
      check(reqName(VEC[k].req), "ccOut", 80'(ccOut), 80'(VEC[k].cc));
      check(reqName(VEC[k].req), "invalid", 80'(invalidOut), 80'(VEC[k].inv));
      check(reqName(VEC[k].req), "denorm", 80'(denormOut), 80'(VEC[k].den));
      check("R11", "done", 80'(doneOut), 80'(1));
      check("R10", "no pop", 80'(popOut), 80'(0));
    end

    // R11: outputs hold and done drops while inputs change without a request
    request(80'h3FFF8000000000000000, 32'h00000002, 1'b0, 1'b0, 1'b0);
    fpIn = 80'h7FFFC000000000000000; intIn = 32'h0; stEmpty = 1'b1;
    @(negedge clk);
    check("R11", "done low", 80'(doneOut), 80'(0));
    check("R11", "cc held", 80'(ccOut), 80'(3'b001));
    check("R11", "invalid held", 80'(invalidOut), 80'(0));
    stEmpty = 1'b0;

    // R9 with R10: empty register, denormal operand, pop requested
    request(80'h00000000000000000001, 32'h00000000, 1'b0, 1'b1, 1'b1);
    check("R9", "ccOut", 80'(ccOut), 80'(3'b111));
    check("R9", "stackFault", 80'(stackFault), 80'(1));
    check("R9", "invalid", 80'(invalidOut), 80'(1));
    check("R9", "denorm", 80'(denormOut), 80'(0));
    check("R10", "pop on empty", 80'(popOut), 80'(1));
    @(negedge clk);
    check("R10", "pop one cycle", 80'(popOut), 80'(0));

    // R10: pop on an ordinary comparison, stack fault cleared again
    request(80'h4001A000000000000000, 32'h00000005, 1'b0, 1'b1, 1'b0);
    check("R10", "pop", 80'(popOut), 80'(1));
    check("R10", "done with pop", 80'(doneOut), 80'(1));
    check("R9", "fault cleared", 80'(stackFault), 80'(0));
    check("R1", "cc after pop", 80'(ccOut), 80'(3'b100));

    // R10: popReq without a request is not forwarded
    @(negedge clk);
    popReq = 1'b1;
    @(negedge clk);
    check("R10", "pop without request", 80'(popOut), 80'(0));
    popReq = 1'b0;

    // R11: back-to-back requests
    @(negedge clk);
    fpIn = 80'h3FFFC000000000000000; intIn = 32'h1; inValid = 1'b1;
    @(negedge clk);
    check("R11", "first done", 80'(doneOut), 80'(1));
    check("R1", "first cc", 80'(ccOut), 80'(3'b000));
    fpIn = 80'hBFFF8000000000000000; intIn = 32'h1;
    @(negedge clk);
    inValid = 1'b0;
    check("R11", "second done", 80'(doneOut), 80'(1));
    check("R1", "second cc", 80'(ccOut), 80'(3'b001));
    @(negedge clk);
    check("R11", "done drops", 80'(doneOut), 80'(0));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule